// File: doc/BRIEF.md
# Byte-Wide Erasable Memory Device Emulator

This block is a synthesizable stand-in for a byte-wide, one-time-programmable-per-erase memory part with 19 address lines and an 8-bit data bus. A controller under test drives it exactly as it would drive the real part. The controller supplies an address, an active-low chip-enable that also acts as the program strobe, an active-low output-enable, a digital flag that says the programming supply is raised, and a digital flag that says the identification high voltage is on address line 9. The block reports whether it is driving the data bus on a separate enable output, which stands in for tri-state. It also takes write data while it is being programmed.

The block works out the operating mode on every cycle from the two enables and the supply flag. It returns stored bytes or the fixed identification bytes, and it commits a program pulse when the strobe rises. A commit can only clear bits. The storage depth is a parameter so that simulation stays small, and upper address bits alias onto it. Erasure is a synchronous command. It sweeps every location to all ones, one location per cycle, and raises a busy flag while it runs. Reset starts the same sweep, so the array always leaves reset erased.

Top module: `eprom_emu`

## Requirements
- R1: With the supply flag low, chip-enable low and output-enable low, `dout_en` is 1 and `dout` equals the stored byte at the address.
- R2: Whenever output-enable is high, `dout_en` is 0 and `dout` is 0x00, whatever the state of chip-enable and the supply flag.
- R3: With the supply flag low and chip-enable high, `dout_en` is 0 and `dout` is 0x00, whatever the state of output-enable.
- R4: With the supply flag high and both enables high (inhibit), the outputs are undriven and the array keeps its contents whatever `din` carries.
- R5: With the supply flag high and output-enable low, outside an open program pulse, the block drives the stored byte at the address (verify). This holds whether chip-enable is high or low.
- R6: A program pulse is a run of cycles with chip-enable low, output-enable high and the supply flag high. It lasts at least MIN_PULSE cycles and commits on the first cycle chip-enable is seen high again. The byte at the address latched in the pulse's last cycle becomes old AND `din`, so bits only go from 1 to 0.
- R7: A program pulse shorter than MIN_PULSE cycles leaves the array unchanged.
- R8: If output-enable goes low while chip-enable is still low in an open program pulse, the outputs stay undriven until chip-enable rises, and the pulse commits nothing.
- R9: With the identification flag high in read or verify mode, `dout` is 0x8F when address bit 0 is 0 and 0x08 when it is 1, in place of array data.
- R10: An `erase_req` pulse while idle raises `erase_busy` for exactly DEPTH cycles and leaves every byte at 0xFF. A request during busy does not extend the sweep, and a program commit during busy is discarded.
- R11: Leaving reset, `erase_busy` is high for exactly DEPTH cycles, after which every location reads 0xFF.
- R12: Address bits above the storage depth are ignored: addresses that agree in their low log2(DEPTH) bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts an erase sweep |
| addr | input | 19 | Byte address |
| ce_n | input | 1 | Active-low chip-enable and program strobe |
| oe_n | input | 1 | Active-low output-enable |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Identification high voltage present on address line 9 |
| din | input | 8 | Data to program |
| erase_req | input | 1 | Start an erase sweep |
| dout | output | 8 | Data out; 0x00 when not driven |
| dout_en | output | 1 | Data bus is driven |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The hardest case to reach is a program commit that falls inside an erase sweep. Reaching it means starting a full pulse of at least MIN_PULSE cycles a couple of cycles after `erase_req`, so that the rising strobe arrives while `erase_busy` is still high. The bench does this, then confirms that the sweep length is unchanged and that the target byte reads 0xFF afterwards. The abort case is reached in a similar way. A legal pulse is held past its minimum length, output-enable is then dropped before the strobe rises, and the bench checks that the bus stays undriven and that the byte keeps its value.

// File: rtl/eprom_emu_pkg.sv
// Package: shared mode encoding and identification bytes for the emulator.
// Assumes an 8-bit data bus.
package eprom_emu_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_OUTDIS  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_PROG    = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5,
        MODE_FAULT   = 3'd6
    } mode_e;

    localparam logic [7:0] ID_MAKER  = 8'h8F;
    localparam logic [7:0] ID_DEVICE = 8'h08;

endpackage

// File: rtl/eprom_mode_dec.sv
// Module: combinational decode of the operating mode from the enables,
// the supply flag and whether a program pulse is currently open.
// Assumes prog_open comes from a register, so no loop is formed.
module eprom_mode_dec
    import eprom_emu_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  prog_open,
    output mode_e mode
);

    // Mode table lookup.
    always_comb begin
        if (!vpp_hi) begin
            if (ce_n)       mode = MODE_STANDBY;
            else if (oe_n)  mode = MODE_OUTDIS;
            else            mode = MODE_READ;
        end else begin
            if (!oe_n)      mode = (!ce_n && prog_open) ? MODE_FAULT : MODE_VERIFY;
            else if (ce_n)  mode = MODE_INHIBIT;
            else            mode = MODE_PROG;
        end
    end

endmodule

// File: rtl/eprom_prog_ctl.sv
// Module: tracks program pulses on the chip-enable strobe, counts their
// length and issues a one-cycle commit on the rising strobe.
// Assumes ce_n is synchronous to clk.
module eprom_prog_ctl
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              prog_open,
    output logic              commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

    logic             in_low;
    logic             spoiled;
    logic [CNT_W-1:0] cnt;

    // Pulse tracking: open flag, spoil flag, saturating length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_low    <= 1'b0;
            prog_open <= 1'b0;
            spoiled   <= 1'b0;
            cnt       <= '0;
        end else if (ce_n) begin
            in_low    <= 1'b0;
            prog_open <= 1'b0;
            spoiled   <= 1'b0;
            cnt       <= '0;
        end else begin
            in_low <= 1'b1;
            if (mode == MODE_PROG) begin
                prog_open <= 1'b1;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else if (prog_open) begin
                spoiled <= 1'b1;
            end
        end
    end

    // Latch address and data during every program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '1;
        end else if (mode == MODE_PROG) begin
            wr_addr <= addr;
            wr_data <= din;
        end
    end

    // Commit on the first strobe-high cycle after a clean, long pulse.
    assign commit = ce_n && in_low && prog_open && !spoiled && (cnt == CNT_MAX);

    assert_commit_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (ce_n && $past(!ce_n)));

endmodule

// File: rtl/eprom_array.sv
// Module: byte storage with AND-only writes and a one-location-per-cycle
// erase sweep, started by request or by reset. Upper address bits alias.
// Assumes writes arrive as one-cycle commits.
module eprom_array #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int DEPTH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int DEPTH = 1 << DEPTH_W;
    localparam logic [DEPTH_W-1:0] LAST = DEPTH_W'(DEPTH - 1);

    logic [DATA_W-1:0]  mem [DEPTH];
    logic [DEPTH_W-1:0] idx;
    logic [DEPTH_W-1:0] wr_idx;
    logic               wr_fire;
    logic [DATA_W-1:0]  wr_old;

    assign wr_idx  = wr_addr[DEPTH_W-1:0];
    assign wr_fire = commit && !busy;
    assign wr_old  = mem[wr_idx];
    assign rd_data = mem[rd_addr[DEPTH_W-1:0]];

    // Erase sequencer: reset or an idle request starts a full sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx == LAST) busy <= 1'b0;
        end else if (erase_req) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end

    // Storage update: sweep writes ones, commits may only clear bits.
    always_ff @(posedge clk) begin
        if (rst_n && busy)  mem[idx]    <= '1;
        else if (wr_fire)   mem[wr_idx] <= wr_old & wr_data;
    end

    assert_and_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> ((mem[$past(wr_idx)] & ~$past(wr_old)) == '0));

    assert_sweep_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(idx) == LAST));

    assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && erase_req && idx != LAST) |=> busy);

endmodule

// File: rtl/eprom_emu.sv
// Module: top of the memory device emulator. Decodes the mode, tracks
// program pulses, holds the array and steers the data bus.
// Assumes all inputs are synchronous to clk; dout is 0x00 when undriven.
module eprom_emu
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int DEPTH_W   = 6,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_req,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              erase_busy
);

    mode_e             mode;
    logic              prog_open;
    logic              commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] id_byte;

    eprom_mode_dec u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_hi    (vpp_hi),
        .prog_open (prog_open),
        .mode      (mode)
    );

    eprom_prog_ctl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MIN_PULSE (MIN_PULSE)
    ) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .mode      (mode),
        .addr      (addr),
        .din       (din),
        .prog_open (prog_open),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    eprom_array #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DEPTH_W (DEPTH_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_req (erase_req),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr),
        .rd_data   (rd_data),
        .busy      (erase_busy)
    );

    // Identification byte chosen by address bit 0.
    assign id_byte = addr[0] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);

    // Output steering: drive only in read and verify modes.
    always_comb begin
        dout_en = (mode == MODE_READ) || (mode == MODE_VERIFY);
        if (!dout_en)   dout = '0;
        else if (a9_hv) dout = id_byte;
        else            dout = rd_data;
    end

    assert_outdis_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |-> !dout_en);

    assert_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi) |-> dout_en);

    assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n && !oe_n && $past(rst_n) && $past(vpp_hi && !ce_n && oe_n))
        |-> !dout_en);

endmodule

// File: tb/tb_eprom_emu.sv
`timescale 1ns/1ps
module tb_eprom_emu;

    localparam int DEPTH_W   = 6;
    localparam int DEPTH     = 1 << DEPTH_W;
    localparam int MIN_PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        vpp_hi = 1'b0;
    logic        a9_hv = 1'b0;
    logic [7:0]  din = 8'hFF;
    logic        erase_req = 1'b0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        erase_busy;

    int total = 0;
    int bad   = 0;
    int busy_cnt = 0;

    always #5 clk = ~clk;

    eprom_emu #(.DEPTH_W(DEPTH_W), .MIN_PULSE(MIN_PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .din(din), .erase_req(erase_req),
        .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
    );

    // Busy length counter, sampled away from the active edge.
    always @(negedge clk) if (erase_busy) busy_cnt <= busy_cnt + 1;

    // Vector: req[35:32] ce oe vpp a9 addr[27:9] en[8] data[7:0]
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {4'd1,  1'b0,1'b0,1'b0,1'b0, 19'd5,      1'b1, 8'h05}, // R1 read
        {4'd1,  1'b0,1'b0,1'b0,1'b0, 19'd6,      1'b1, 8'hFF}, // R1 read erased
        {4'd2,  1'b0,1'b1,1'b0,1'b0, 19'd5,      1'b0, 8'h00}, // R2 output disable
        {4'd3,  1'b1,1'b0,1'b0,1'b0, 19'd5,      1'b0, 8'h00}, // R3 standby oe low
        {4'd3,  1'b1,1'b1,1'b0,1'b0, 19'd5,      1'b0, 8'h00}, // R3 standby oe high
        {4'd4,  1'b1,1'b1,1'b1,1'b0, 19'd5,      1'b0, 8'h00}, // R4 inhibit
        {4'd5,  1'b1,1'b0,1'b1,1'b0, 19'd5,      1'b1, 8'h05}, // R5 verify ce high
        {4'd9,  1'b0,1'b0,1'b0,1'b1, 19'd0,      1'b1, 8'h8F}, // R9 maker id
        {4'd9,  1'b0,1'b0,1'b0,1'b1, 19'd1,      1'b1, 8'h08}, // R9 device id
        {4'd9,  1'b1,1'b0,1'b1,1'b1, 19'd2,      1'b1, 8'h8F}, // R9 id in verify
        {4'd12, 1'b0,1'b0,1'b0,1'b0, 19'd69,     1'b1, 8'h05}, // R12 alias
        {4'd12, 1'b0,1'b0,1'b0,1'b0, 19'h7FFC5,  1'b1, 8'h05}  // R12 alias top
    };

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; vpp_hi = 1'b0; a9_hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1 v = dout;
        @(negedge clk);
        idle_bus();
    endtask

    // Program pulse of len low cycles, then strobe high for the commit edge.
    task automatic prog(input logic [18:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        addr = a; din = d; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        for (int i = 0; i < len; i++) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        vpp_hi = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        busy_cnt = 0;
        rst_n = 1'b1;
        #1 chk("R11 busy after reset", erase_busy, 1);
        wait (!erase_busy);
        @(negedge clk);
        chk("R11 sweep length", busy_cnt, DEPTH);
        rd(19'd0, v);  chk("R11 erased 0", v, 8'hFF);
        rd(19'd63, v); chk("R11 erased 63", v, 8'hFF);

        prog(19'd5, 8'hA5, MIN_PULSE);
        rd(19'd5, v);  chk("R6 program", v, 8'hA5);
        prog(19'd5, 8'h0F, MIN_PULSE + 3);
        rd(19'd5, v);  chk("R6 and-only", v, 8'h05);
        prog(19'd6, 8'h3C, MIN_PULSE - 1);
        rd(19'd6, v);  chk("R7 short pulse", v, 8'hFF);

        // R8: drop output-enable inside an open pulse.
        @(negedge clk);
        addr = 19'd7; din = 8'h12; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        repeat (MIN_PULSE + 1) @(negedge clk);
        oe_n = 1'b0;
        #1 chk("R8 undriven", dout_en, 0);
        @(negedge clk);
        #1 chk("R8 still undriven", dout_en, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        idle_bus();
        rd(19'd7, v);  chk("R8 no commit", v, 8'hFF);

        // R4: inhibit with zero data must not write.
        @(negedge clk);
        addr = 19'd8; din = 8'h00; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        idle_bus();
        rd(19'd8, v);  chk("R4 inhibit no write", v, 8'hFF);

        // R5: verify with chip-enable low, entered without a program cycle.
        @(negedge clk);
        addr = 19'd5; vpp_hi = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        #1 chk("R5 verify ce low en", dout_en, 1);
        chk("R5 verify ce low data", dout, 8'h05);
        @(negedge clk);
        idle_bus();

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            ce_n = VEC[k][31]; oe_n = VEC[k][30]; vpp_hi = VEC[k][29];
            a9_hv = VEC[k][28]; addr = VEC[k][27:9];
            #1;
            chk($sformatf("R%0d vec%0d en", VEC[k][35:32], k), dout_en, VEC[k][8]);
            chk($sformatf("R%0d vec%0d data", VEC[k][35:32], k), dout, VEC[k][7:0]);
        end
        @(negedge clk);
        idle_bus();

        // R10: erase with a repeated request and a program during the sweep.
        @(negedge clk);
        busy_cnt = 0;
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        chk("R10 busy raised", erase_busy, 1);
        prog(19'd9, 8'h00, MIN_PULSE);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        wait (!erase_busy);
        @(negedge clk);
        chk("R10 sweep length", busy_cnt, DEPTH);
        rd(19'd5, v);  chk("R10 erased", v, 8'hFF);
        rd(19'd9, v);  chk("R10 commit discarded", v, 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule